// File: doc/BRIEF.md
# I2C Bit-Level Bus Timing Generator

This block turns single bit-level requests from a transfer sequencer (begin a transfer, end a transfer, send one bit, receive one bit) into the SCL and SDA waveforms of an I2C bus master. It drives both lines through open-drain enables, where a 1 pulls the line low. It reads both lines back through a glitch filter. Four independent system-clock counts set the timing. One sets the whole SCL period. One sets the SCL low time. One sets the hold time after a START and the setup time before a repeated START or STOP. The last sets how long SDA settles before SCL is released. Software normally derives these from one ratio: the period is the clock rate over the bus rate, at most 400 kHz. The low count is 5/9 of the period, the setup count is half of it, and the data-settle count is a sixteenth of it.

The high phase of each bit is counted from the moment the filtered SCL is seen high. A slave that holds SCL low therefore stretches the bit. Receive data is sampled in the middle of the high phase. If SDA reads low while the master releases it to send a 1, a lost-arbitration flag is raised. Two control inputs are provided. A run enable gates command acceptance. A release control lets the host force SCL low while the bus is free, which is used to recover a stuck bus. The filtered line levels are exported for monitoring.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset, neither line is driven (`scl_oe`=0, `sda_oe`=0), `done`, `bus_busy`, `stop_seen` and `arb_lost` are 0, `mon_scl`/`mon_sda` read 1, and `cmd_ready` equals `run_en`.
- R2: Command codes on `cmd_op` are 0 = START, 1 = STOP, 2 = WRITE (send `cmd_bit`), 3 = READ. A START accepted while `bus_busy`=0 pulls SDA low in the accepting cycle. After `cfg_setup` cycles it pulls SCL low and pulses `done`. `bus_busy` becomes 1 and `stop_seen` 0.
- R3: A WRITE or READ accepted at cycle A releases SCL at A+`cfg_low`. The new SDA level appears at A+`cfg_low`−`cfg_dsu`. During a bit, SDA changes only while SCL is driven low.
- R4: The high phase lasts `cfg_period`−`cfg_low` cycles. It starts on the second cycle after the filtered SCL reads high, so a slave holding SCL low delays `done` one cycle per held cycle. At `done`, SCL is driven low again.
- R5: A WRITE leaves `sda_oe` = NOT `cmd_bit`. A READ releases SDA, and `rd_bit` returns the filtered SDA level sampled in the middle of the high phase.
- R6: A WRITE of 1 that samples SDA low sets `arb_lost`. A WRITE of 0 does not set it. The flag holds until the next START clears it.
- R7: A START accepted while `bus_busy`=1 (repeated START) releases SDA at once and releases SCL after `cfg_low` cycles. After SCL is seen high it waits `cfg_setup`, pulls SDA low, waits `cfg_setup` again, then pulls SCL low and pulses `done`.
- R8: A STOP pulls SDA low, releases SCL after `cfg_low`, and waits `cfg_setup` after SCL is seen high. It then releases SDA, clears `bus_busy` and sets `stop_seen`. It pulses `done` only after a further `cfg_low` cycles of bus-free time.
- R9: A STOP, WRITE or READ accepted while `bus_busy`=0 is dropped. No `done` follows, and neither line is driven.
- R10: While `bus_busy`=0 and `scl_release`=0, `scl_oe` is 1 from the next cycle on. It returns to 0 the cycle after `scl_release` returns to 1.
- R11: While `run_en`=0, `cmd_ready` is 0 and a held request has no effect.
- R12: Each filtered line level changes only after the raw input has held the new value for `FILT_LEN` consecutive samples. A shorter pulse is not seen on `mon_scl`/`mon_sda`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Allow command acceptance |
| scl_release | input | 1 | 0 forces SCL low while the bus is free |
| cfg_period | input | CNT_W | System clocks per SCL period |
| cfg_low | input | CNT_W | SCL low time in clocks |
| cfg_setup | input | CNT_W | START hold, repeated-START and STOP setup in clocks |
| cfg_dsu | input | CNT_W | SDA settle time before SCL release |
| cmd_valid | input | 1 | Request present |
| cmd_op | input | 2 | Request code (see R2) |
| cmd_bit | input | 1 | Bit to send for WRITE |
| cmd_ready | output | 1 | Request accepted when high with cmd_valid |
| done | output | 1 | One-cycle completion pulse |
| rd_bit | output | 1 | Last received bit |
| arb_lost | output | 1 | Lost arbitration flag |
| bus_busy | output | 1 | Bus owned between START and STOP |
| stop_seen | output | 1 | A STOP has completed since the last START |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| mon_scl | output | 1 | Filtered SCL level |
| mon_sda | output | 1 | Filtered SDA level |

## Verification
A phase counter that loads the wrong count or skips a phase moves the cycle of an SCL release or of `done` by at least one clock. Every such timestamp is compared with a value derived from the four counts and the filter delay, so the fault shows on the same transfer. A wrong state in the bit path shows up in two ways: SDA moves while SCL is released, or the read or arbitration sample is taken from the wrong level. Either shows at `sda_oe`, `rd_bit` or `arb_lost` by the end of that bit. A filter that settles too early or too late shifts `mon_sda` within `FILT_LEN`+1 cycles of a pulse.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } bt_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RS_LO, S_RS_WH, S_RS_H, S_ST_HOLD,
    S_B_LO1, S_B_LO2, S_B_WH, S_B_H,
    S_SP_LO, S_SP_WH, S_SP_H, S_BUF
  } bt_state_e;
endpackage

// File: rtl/i2c_bt_filt.sv
module i2c_bt_filt #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [LEN-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '1;
      dout <= 1'b1;
    end else begin
      hist <= {hist[LEN-2:0], din};
      if (&hist)       dout <= 1'b1;
      else if (~|hist) dout <= 1'b0;
    end
  end

  // R12: a new filtered level must have been present on the raw input
  p_filter_follows_r12: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> ($past(din) == dout));
endmodule

// File: rtl/i2c_bt_seq.sv
module i2c_bt_seq
  import i2c_bt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_dsu,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_bit,
  input  logic             scl_f,
  input  logic             sda_f,
  output logic             cmd_ready,
  output logic             done,
  output logic             rd_bit,
  output logic             arb_lost,
  output logic             bus_busy,
  output logic             stop_seen,
  output logic             drv_scl,
  output logic             drv_sda
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  bt_state_e        st;
  bt_op_e           op_q;
  logic             bit_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] t_high, t_mid, t_lo1;
  logic             last, fire;

  assign t_high    = cfg_period - cfg_low;
  assign t_mid     = t_high - (t_high >> 1);
  assign t_lo1     = cfg_low - cfg_dsu;
  assign last      = (cnt <= ONE);
  assign cmd_ready = (st == S_IDLE) && run_en;
  assign fire      = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      op_q      <= OP_WRITE;
      bit_q     <= 1'b0;
      cnt       <= '0;
      drv_scl   <= 1'b0;
      drv_sda   <= 1'b0;
      bus_busy  <= 1'b0;
      stop_seen <= 1'b0;
      arb_lost  <= 1'b0;
      rd_bit    <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cnt != '0) cnt <= cnt - ONE;
      case (st)
        S_IDLE: if (fire) begin
          op_q  <= bt_op_e'(cmd_op);
          bit_q <= cmd_bit;
          case (bt_op_e'(cmd_op))
            OP_START: begin
              bus_busy  <= 1'b1;
              stop_seen <= 1'b0;
              arb_lost  <= 1'b0;
              if (bus_busy) begin
                st <= S_RS_LO;  drv_sda <= 1'b0; cnt <= cfg_low;
              end else begin
                st <= S_ST_HOLD; drv_sda <= 1'b1; cnt <= cfg_setup;
              end
            end
            OP_STOP: if (bus_busy) begin
              st <= S_SP_LO; drv_sda <= 1'b1; cnt <= cfg_low;
            end
            default: if (bus_busy) begin
              st <= S_B_LO1; cnt <= t_lo1;
            end
          endcase
        end
        S_RS_LO:   if (last) begin st <= S_RS_WH; drv_scl <= 1'b0; end
        S_RS_WH:   if (scl_f) begin st <= S_RS_H; cnt <= cfg_setup; end
        S_RS_H:    if (last) begin st <= S_ST_HOLD; drv_sda <= 1'b1; cnt <= cfg_setup; end
        S_ST_HOLD: if (last) begin st <= S_IDLE; drv_scl <= 1'b1; done <= 1'b1; end
        S_B_LO1:   if (last) begin
          st      <= S_B_LO2;
          drv_sda <= (op_q == OP_WRITE) ? ~bit_q : 1'b0;
          cnt     <= cfg_dsu;
        end
        S_B_LO2:   if (last) begin st <= S_B_WH; drv_scl <= 1'b0; end
        S_B_WH:    if (scl_f) begin st <= S_B_H; cnt <= t_high; end
        S_B_H: begin
          if (cnt == t_mid) begin
            if (op_q == OP_READ) rd_bit <= sda_f;
            if (op_q == OP_WRITE && bit_q && !sda_f) arb_lost <= 1'b1;
          end
          if (last) begin st <= S_IDLE; drv_scl <= 1'b1; done <= 1'b1; end
        end
        S_SP_LO:   if (last) begin st <= S_SP_WH; drv_scl <= 1'b0; end
        S_SP_WH:   if (scl_f) begin st <= S_SP_H; cnt <= cfg_setup; end
        S_SP_H:    if (last) begin
          st <= S_BUF; drv_sda <= 1'b0; bus_busy <= 1'b0; stop_seen <= 1'b1; cnt <= cfg_low;
        end
        S_BUF:     if (last) begin st <= S_IDLE; done <= 1'b1; end
        default:   st <= S_IDLE;
      endcase
    end
  end

  // R3: inside a bit, SDA may only move while SCL was being held low
  p_sda_moves_low_r3: assert property (@(posedge clk) disable iff (rst)
    ((drv_sda != $past(drv_sda)) && ($past(st) inside {S_B_LO1, S_B_LO2, S_B_WH, S_B_H}))
      |-> $past(drv_scl));

  // R4: the completion strobe lasts a single cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: bit or stop requests on a free bus are dropped
  p_drop_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (fire && !bus_busy && (cmd_op != OP_START)) |=> (st == S_IDLE && !done && !drv_sda));

  // R8: the bus only becomes free together with the stop indication
  p_free_with_stop_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_busy) |-> stop_seen);

  // R11: nothing is taken while not running
  p_gate_r11: assert property (@(posedge clk) disable iff (rst)
    (!run_en && st == S_IDLE) |=> (st == S_IDLE));
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer #(
  parameter int CNT_W    = 16,
  parameter int FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             scl_release,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_dsu,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_bit,
  output logic             cmd_ready,
  output logic             done,
  output logic             rd_bit,
  output logic             arb_lost,
  output logic             bus_busy,
  output logic             stop_seen,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             mon_scl,
  output logic             mon_sda
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, filt;
  logic              drv_scl, drv_sda, man_low;

  assign raw = {sda_in, scl_in};

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    i2c_bt_filt #(.LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .din  (raw[i]),
      .dout (filt[i])
    );
  end

  i2c_bt_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .cfg_period (cfg_period),
    .cfg_low    (cfg_low),
    .cfg_setup  (cfg_setup),
    .cfg_dsu    (cfg_dsu),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_bit    (cmd_bit),
    .scl_f      (filt[0]),
    .sda_f      (filt[1]),
    .cmd_ready  (cmd_ready),
    .done       (done),
    .rd_bit     (rd_bit),
    .arb_lost   (arb_lost),
    .bus_busy   (bus_busy),
    .stop_seen  (stop_seen),
    .drv_scl    (drv_scl),
    .drv_sda    (drv_sda)
  );

  always_ff @(posedge clk) begin
    if (rst) man_low <= 1'b0;
    else     man_low <= !scl_release && !bus_busy;
  end

  assign scl_oe  = drv_scl | man_low;
  assign sda_oe  = drv_sda;
  assign mon_scl = filt[0];
  assign mon_sda = filt[1];

  // R10: a free bus with release withdrawn has SCL pulled low next cycle
  p_manual_low_r10: assert property (@(posedge clk) disable iff (rst)
    (!bus_busy && !scl_release) |=> scl_oe);
endmodule

// File: tb/i2c_bit_timer_tb.sv
module i2c_bit_timer_tb;
  localparam int CLK_PER = 10;
  localparam int CW      = 16;
  localparam int FLT     = 3;
  localparam int DLY     = FLT + 2;
  localparam logic [1:0] C_START = 2'd0, C_STOP = 2'd1, C_WRITE = 2'd2, C_READ = 2'd3;

  logic clk = 1'b0, rst = 1'b1, run_en = 1'b1, scl_release = 1'b1;
  logic [CW-1:0] cfg_period = 18, cfg_low = 10, cfg_setup = 9, cfg_dsu = 1;
  logic cmd_valid = 1'b0, cmd_bit = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic cmd_ready, done, rd_bit, arb_lost, bus_busy, stop_seen;
  logic scl_oe, sda_oe, mon_scl, mon_sda, scl_in, sda_in;
  logic slv_scl_low = 1'b0, slv_sda_low = 1'b0;

  assign scl_in = ~scl_oe & ~slv_scl_low;
  assign sda_in = ~sda_oe & ~slv_sda_low;

  i2c_bit_timer #(.CNT_W(CW), .FILT_LEN(FLT)) u_dut (
    .clk(clk), .rst(rst), .run_en(run_en), .scl_release(scl_release),
    .cfg_period(cfg_period), .cfg_low(cfg_low), .cfg_setup(cfg_setup), .cfg_dsu(cfg_dsu),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit), .cmd_ready(cmd_ready),
    .done(done), .rd_bit(rd_bit), .arb_lost(arb_lost), .bus_busy(bus_busy),
    .stop_seen(stop_seen), .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .mon_scl(mon_scl), .mon_sda(mon_sda)
  );

  always #(CLK_PER/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  int r_a, r_rel, r_sf, r_sl, r_done, r_hichg;
  int lo, su, ds, th;
  logic exp_sda;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic b, input int stretch);
    logic ps, pc;
    int n;
    bit fin;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R11 ready before request", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_op = op; cmd_bit = b;
    ps = sda_oe; pc = scl_oe;
    if (stretch > 0) slv_scl_low = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    r_a = cyc; r_rel = -1; r_sf = -1; r_sl = -1; r_done = -1; r_hichg = 0;
    fin = 0; n = 0;
    while (!fin) begin
      if (pc && !scl_oe && r_rel < 0) r_rel = cyc;
      if (sda_oe != ps) begin
        if (r_sf < 0) r_sf = cyc;
        r_sl = cyc;
        if (!pc) r_hichg++;
      end
      if (slv_scl_low && r_rel >= 0 && cyc >= r_rel + stretch) slv_scl_low = 1'b0;
      ps = sda_oe; pc = scl_oe;
      if (done) begin
        r_done = cyc; fin = 1;
      end else begin
        n++;
        if (n > 4000) fin = 1;
        else @(negedge clk);
      end
    end
  endtask

  task automatic do_start_idle();
    run_op(C_START, 1'b0, 0);
    chk(r_sf == r_a, "R2 SDA pulled at acceptance", r_sf, r_a);
    chk(r_done == r_a + su, "R2 done after hold", r_done, r_a + su);
    chk(scl_oe && sda_oe, "R2 both lines low at done", {scl_oe, sda_oe}, 3);
    chk(bus_busy && !stop_seen, "R2 busy set stop cleared", {bus_busy, stop_seen}, 2);
    chk(arb_lost == 1'b0, "R6 START clears arbitration flag", arb_lost, 0);
    exp_sda = 1'b1;
  endtask

  task automatic do_bit(input logic [1:0] op, input logic b, input int stretch);
    logic nv;
    nv = (op == C_WRITE) ? ~b : 1'b0;
    if (op == C_READ) slv_sda_low = ~b;
    run_op(op, b, stretch);
    chk(r_rel == r_a + lo, "R3 SCL release time", r_rel, r_a + lo);
    chk(r_done == r_a + lo + stretch + DLY + th, "R4 bit done time", r_done, r_a + lo + stretch + DLY + th);
    chk(r_hichg == 0, "R3 SDA moved with SCL released", r_hichg, 0);
    if (nv != exp_sda)
      chk(r_sf == r_a + lo - ds, "R3 SDA settle point", r_sf, r_a + lo - ds);
    chk(sda_oe == nv, "R5 SDA drive after bit", sda_oe, nv);
    chk(scl_oe == 1'b1, "R4 SCL low again at done", scl_oe, 1);
    if (op == C_READ) begin
      chk(rd_bit == b, "R5 received bit", rd_bit, b);
      slv_sda_low = 1'b0;
    end
    exp_sda = nv;
  endtask

  task automatic do_restart();
    run_op(C_START, 1'b0, 0);
    chk(r_rel == r_a + lo, "R7 repeated START SCL release", r_rel, r_a + lo);
    chk(r_sl == r_a + lo + DLY + su, "R7 repeated START SDA fall", r_sl, r_a + lo + DLY + su);
    chk(r_done == r_a + lo + DLY + 2 * su, "R7 repeated START done", r_done, r_a + lo + DLY + 2 * su);
    chk(scl_oe && sda_oe && bus_busy, "R7 lines held after repeated START", {scl_oe, sda_oe, bus_busy}, 7);
    exp_sda = 1'b1;
  endtask

  task automatic do_stop();
    run_op(C_STOP, 1'b0, 0);
    chk(r_rel == r_a + lo, "R8 STOP SCL release", r_rel, r_a + lo);
    chk(r_sl == r_a + lo + DLY + su, "R8 STOP SDA release", r_sl, r_a + lo + DLY + su);
    chk(r_done == r_a + lo + DLY + su + lo, "R8 STOP done after bus-free time", r_done, r_a + lo + DLY + su + lo);
    chk(!bus_busy && stop_seen, "R8 busy clear and stop flag", {bus_busy, stop_seen}, 1);
    chk(!scl_oe && !sda_oe && cmd_ready, "R8 lines free and ready", {scl_oe, sda_oe, cmd_ready}, 1);
    exp_sda = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PER * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
  end

  initial begin
    int per[4] = '{18, 27, 36, 20};
    int low[4] = '{10, 15, 20, 7};
    int sup[4] = '{9, 13, 18, 3};
    int dsu[4] = '{1, 1, 2, 4};
    logic [7:0] pat;
    int t0;
    exp_sda = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(!done && !bus_busy && !stop_seen && !arb_lost, "R1 status clear",
        {done, bus_busy, stop_seen, arb_lost}, 0);
    chk(mon_scl && mon_sda && cmd_ready, "R1 monitor high and ready", {mon_scl, mon_sda, cmd_ready}, 7);

    for (int k = 0; k < 4; k++) begin
      cfg_period = CW'(per[k]); cfg_low = CW'(low[k]); cfg_setup = CW'(sup[k]); cfg_dsu = CW'(dsu[k]);
      lo = low[k]; su = sup[k]; ds = dsu[k]; th = per[k] - low[k];
      pat = 8'hB4 ^ 8'(k * 37);
      do_start_idle();
      for (int i = 7; i >= 0; i--) do_bit(C_WRITE, pat[i], (k == 0 && i == 6) ? 9 : 0);
      for (int i = 0; i < 4; i++) do_bit(C_READ, pat[i] ^ 1'b1, 0);
      do_restart();
      slv_sda_low = 1'b1;
      do_bit(C_WRITE, 1'b0, 0);
      chk(arb_lost == 1'b0, "R6 zero bit never flags", arb_lost, 0);
      do_bit(C_WRITE, 1'b1, 0);
      chk(arb_lost == 1'b1, "R6 released bit read low flags", arb_lost, 1);
      slv_sda_low = 1'b0;
      do_stop();
    end

    // R9 requests on a free bus
    for (int op = 1; op < 4; op++) begin
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'(op); cmd_bit = 1'b0;
      @(negedge clk);
      cmd_valid = 1'b0;
      begin
        int seen;
        seen = 0;
        for (int i = 0; i < 60; i++) begin
          if (done || scl_oe || sda_oe) seen++;
          @(negedge clk);
        end
        chk(seen == 0, "R9 dropped request left bus untouched", seen, 0);
        chk(!bus_busy && cmd_ready, "R9 still free and ready", {bus_busy, cmd_ready}, 1);
      end
    end

    // R10 manual SCL
    @(negedge clk);
    scl_release = 1'b0;
    chk(scl_oe == 1'b0, "R10 not yet forced", scl_oe, 0);
    @(negedge clk);
    chk(scl_oe == 1'b1, "R10 forced low", scl_oe, 1);
    scl_release = 1'b1;
    @(negedge clk);
    chk(scl_oe == 1'b0, "R10 released again", scl_oe, 0);

    // R11 run gate
    @(negedge clk);
    run_en = 1'b0;
    cmd_valid = 1'b1; cmd_op = C_START;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (cmd_ready || done || sda_oe || bus_busy) seen++;
      end
      chk(seen == 0, "R11 held request ignored while stopped", seen, 0);
    end
    cmd_valid = 1'b0;
    run_en = 1'b1;
    lo = 10; su = 9; ds = 1; th = 8;
    cfg_period = 18; cfg_low = 10; cfg_setup = 9; cfg_dsu = 1;
    do_start_idle();
    do_stop();

    // R12 glitch filter on SDA
    repeat (5) @(negedge clk);
    slv_sda_low = 1'b1; t0 = cyc;
    repeat (FLT - 1) @(negedge clk);
    slv_sda_low = 1'b0;
    begin
      int dips;
      dips = 0;
      for (int i = 0; i < 8; i++) begin
        if (!mon_sda) dips++;
        @(negedge clk);
      end
      chk(dips == 0, "R12 short pulse filtered", dips, 0);
    end
    slv_sda_low = 1'b1; t0 = cyc;
    repeat (FLT) @(negedge clk);
    chk(mon_sda == 1'b1 && cyc == t0 + FLT, "R12 level held before settle", mon_sda, 1);
    @(negedge clk);
    chk(mon_sda == 1'b0, "R12 level follows after full count", mon_sda, 0);
    slv_sda_low = 1'b0;
    repeat (FLT + 2) @(negedge clk);
    chk(mon_sda == 1'b1, "R12 level restored", mon_sda, 1);

    summary();
  end
endmodule